// File: doc/BRIEF.md
# Coded Frame Label Assembler

This block gathers one frame's worth of scrambled 65-bit blocks. It closes the gathered data with an 8-bit CRC and a single auxiliary channel bit. It then splits the resulting payload into two parts. One part is a systematic section, which goes out on a wide port to an external LDPC encoder. The other part stays uncoded.

The block waits for the encoder to return its parity bits. It then walks through the uncoded bits and the codeword bits together and emits one 7-bit constellation label per clock, with a strobe on the first label. While a frame is being encoded or emitted, the block holds its ready output low, so the block source stalls.

Top module: `ldpc_frame_asm`

## Requirements
- R1: After reset, `blk_ready_o` is 1, and `enc_req_o`, `label_valid_o` and `label_sof_o` are 0.
- R2: The block accepts a 65-bit block on every clock edge where both `blk_valid_i` and `blk_ready_o` are 1, and ignores the data when valid is 0. After exactly 50 blocks have been accepted, `blk_ready_o` drops in the next cycle.
- R3: Accepted block k (counting from 0) bit j is placed at payload position 65k+j. While `enc_req_o` is 1, `sys_bits_o` equals payload bits 1722..0.
- R4: The CRC register uses the polynomial x^8+x^2+x+1 (0x07) and starts at zero for each frame. The 3250 block bits are shifted in MSB-first into the register, in payload order: the feedback is crc[7] XOR the data bit, the register shifts left, and the polynomial is XORed in when the feedback is 1. Final crc[i] sits at payload position 3250+i.
- R5: The `aux_i` value sampled together with the 50th accepted block sits at payload position 3258. Values of `aux_i` at other times have no effect.
- R6: `enc_req_o` rises in the cycle after the 50th block is accepted. It stays high, and no label is emitted, until `parity_valid_i` is sampled high.
- R7: Label 0 appears in the cycle after `parity_valid_i` is sampled with `enc_req_o` high. Labels 0..511 follow on 512 consecutive cycles, and `label_sof_o` is 1 only with label 0.
- R8: Uncoded bit u[i] is payload bit 1723+i. Codeword bit c[i] is payload bit i for i<1723, and parity bit i-1723 otherwise. Label n carries u[3n+b] at bit b (b=0..2) and c[4n+b] at bit 3+b (b=0..3).
- R9: `blk_ready_o` stays 0 from the end of gathering until the last label. Blocks offered in that time are ignored. `blk_ready_o` is 1 again in the cycle after label 511.
- R10: Consecutive frames are independent. Each frame's CRC and content depend only on that frame's blocks, auxiliary bit and parity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blk_valid_i | input | 1 | Input block valid |
| blk_data_i | input | 65 | Scrambled 65-bit block |
| blk_ready_o | output | 1 | Block accepted when high with valid |
| aux_i | input | 1 | Auxiliary channel bit, sampled with the last block |
| enc_req_o | output | 1 | Systematic bits are ready for the encoder |
| sys_bits_o | output | 1723 | Systematic bits sent to the encoder |
| parity_valid_i | input | 1 | Encoder parity return is valid |
| parity_i | input | 325 | Encoder parity bits |
| label_valid_o | output | 1 | Label output valid |
| label_sof_o | output | 1 | First label of a frame |
| label_o | output | 7 | Label: bits 2..0 uncoded, bits 6..3 coded |

## Verification
The bench runs four kinds of frames:
- Random blocks with random valid gaps. These check that the gaps do not shift the payload positions.
- All-zero blocks. These make the CRC zero, which exposes a wrong preset or a stuck bit.
- All-ones blocks. These check the polynomial taps and the bit order of the CRC.
- Back-to-back random frames with different encoder delays. These separate per-frame CRC restart and parity wait errors from data path errors.

Garbage blocks offered while the frame is busy, and auxiliary values that differ from the one sampled, show whether these inputs leak into the payload.

// File: rtl/ldpc_frame_pkg.sv
package ldpc_frame_pkg;
  typedef enum logic [1:0] {
    ST_FILL = 2'd0,
    ST_ENC  = 2'd1,
    ST_EMIT = 2'd2
  } asm_state_e;
endpackage

// File: rtl/ldpc_frame_crc.sv
module ldpc_frame_crc #(
  parameter int          DW   = 65,
  parameter int          CW   = 8,
  parameter logic [CW-1:0] POLY = 8'h07
) (
  input  logic [CW-1:0] crc_i,
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] crc_o
);
  always_comb begin
    logic [CW-1:0] c;
    logic          fb;
    c = crc_i;
    for (int i = 0; i < DW; i++) begin
      fb = c[CW-1] ^ data_i[i];
      c  = {c[CW-2:0], 1'b0} ^ (fb ? POLY : '0);
    end
    crc_o = c;
  end
endmodule

// File: rtl/ldpc_frame_store.sv
module ldpc_frame_store #(
  parameter int BLK_W   = 65,
  parameter int NUM_BLK = 50,
  parameter int CRC_W   = 8,
  parameter int SYS_W   = 1723,
  parameter int UNC_W   = 1536,
  parameter int PAR_W   = 325,
  localparam int DATA_W = BLK_W * NUM_BLK,
  localparam int PAY_W  = DATA_W + CRC_W + 1,
  localparam int IDX_W  = $clog2(NUM_BLK)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               blk_we_i,
  input  logic [IDX_W-1:0]   blk_idx_i,
  input  logic [BLK_W-1:0]   blk_data_i,
  input  logic               tail_we_i,
  input  logic [CRC_W-1:0]   crc_i,
  input  logic               aux_i,
  input  logic               par_we_i,
  input  logic [PAR_W-1:0]   par_i,
  output logic [SYS_W-1:0]   sys_o,
  output logic [UNC_W-1:0]   unc_o,
  output logic [PAR_W-1:0]   par_o
);
  logic [BLK_W-1:0] blk_q [NUM_BLK];
  logic [CRC_W-1:0] crc_q;
  logic             aux_q;
  logic [PAR_W-1:0] par_q;
  logic [PAY_W-1:0] pay;

  for (genvar k = 0; k < NUM_BLK; k++) begin : g_blk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 blk_q[k] <= '0;
      else if (blk_we_i && blk_idx_i == IDX_W'(k)) blk_q[k] <= blk_data_i;
    end
    assign pay[k*BLK_W +: BLK_W] = blk_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      crc_q <= '0;
      aux_q <= 1'b0;
      par_q <= '0;
    end else begin
      if (tail_we_i) begin
        crc_q <= crc_i;
        aux_q <= aux_i;
      end
      if (par_we_i) par_q <= par_i;
    end
  end

  assign pay[DATA_W +: CRC_W] = crc_q;
  assign pay[PAY_W-1]         = aux_q;
  assign sys_o = pay[SYS_W-1:0];
  assign unc_o = pay[PAY_W-1:SYS_W];
  assign par_o = par_q;
endmodule

// File: rtl/ldpc_frame_label.sv
module ldpc_frame_label #(
  parameter int NUM_LBL = 512,
  parameter int UNC_PL  = 3,
  parameter int COD_PL  = 4,
  parameter int SYS_W   = 1723,
  localparam int UNC_W  = NUM_LBL * UNC_PL,
  localparam int CW_W   = NUM_LBL * COD_PL,
  localparam int PAR_W  = CW_W - SYS_W,
  localparam int LI_W   = $clog2(NUM_LBL)
) (
  input  logic [LI_W-1:0]          idx_i,
  input  logic [UNC_W-1:0]         unc_i,
  input  logic [SYS_W-1:0]         sys_i,
  input  logic [PAR_W-1:0]         par_i,
  output logic [UNC_PL+COD_PL-1:0] label_o
);
  logic [NUM_LBL-1:0][UNC_PL-1:0] unc_arr;
  logic [NUM_LBL-1:0][COD_PL-1:0] cw_arr;

  assign unc_arr = unc_i;
  assign cw_arr  = {par_i, sys_i};
  assign label_o = {cw_arr[idx_i], unc_arr[idx_i]};
endmodule

// File: rtl/ldpc_frame_asm.sv
module ldpc_frame_asm
  import ldpc_frame_pkg::*;
#(
  parameter int BLK_W   = 65,
  parameter int NUM_BLK = 50,
  parameter int CRC_W   = 8,
  parameter logic [CRC_W-1:0] CRC_POLY = 8'h07,
  parameter int NUM_LBL = 512,
  parameter int UNC_PL  = 3,
  parameter int COD_PL  = 4,
  localparam int PAY_W  = BLK_W * NUM_BLK + CRC_W + 1,
  localparam int UNC_W  = NUM_LBL * UNC_PL,
  localparam int SYS_W  = PAY_W - UNC_W,
  localparam int PAR_W  = NUM_LBL * COD_PL - SYS_W,
  localparam int LBL_W  = UNC_PL + COD_PL,
  localparam int IDX_W  = $clog2(NUM_BLK),
  localparam int LI_W   = $clog2(NUM_LBL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             blk_valid_i,
  input  logic [BLK_W-1:0] blk_data_i,
  output logic             blk_ready_o,
  input  logic             aux_i,
  output logic             enc_req_o,
  output logic [SYS_W-1:0] sys_bits_o,
  input  logic             parity_valid_i,
  input  logic [PAR_W-1:0] parity_i,
  output logic             label_valid_o,
  output logic             label_sof_o,
  output logic [LBL_W-1:0] label_o
);
  asm_state_e       state_q;
  logic [IDX_W-1:0] blk_cnt_q;
  logic [LI_W-1:0]  lbl_cnt_q;
  logic [CRC_W-1:0] crc_q, crc_nxt;
  logic             accept, last_blk, par_take, last_lbl;
  logic [UNC_W-1:0] unc_bits;
  logic [PAR_W-1:0] par_bits;

  assign accept   = (state_q == ST_FILL) && blk_valid_i;
  assign last_blk = accept && (blk_cnt_q == IDX_W'(NUM_BLK - 1));
  assign par_take = (state_q == ST_ENC) && parity_valid_i;
  assign last_lbl = (state_q == ST_EMIT) && (lbl_cnt_q == LI_W'(NUM_LBL - 1));

  ldpc_frame_crc #(.DW(BLK_W), .CW(CRC_W), .POLY(CRC_POLY)) crc_i (
    .crc_i (crc_q),
    .data_i(blk_data_i),
    .crc_o (crc_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_FILL;
      blk_cnt_q <= '0;
      lbl_cnt_q <= '0;
      crc_q     <= '0;
    end else begin
      unique case (state_q)
        ST_FILL: if (accept) begin
          if (last_blk) begin
            blk_cnt_q <= '0;
            crc_q     <= '0;   // restart for next frame
            state_q   <= ST_ENC;
          end else begin
            blk_cnt_q <= blk_cnt_q + 1'b1;
            crc_q     <= crc_nxt;
          end
        end
        ST_ENC: if (par_take) begin
          lbl_cnt_q <= '0;
          state_q   <= ST_EMIT;
        end
        ST_EMIT: begin
          lbl_cnt_q <= lbl_cnt_q + 1'b1;
          if (last_lbl) state_q <= ST_FILL;
        end
        default: state_q <= ST_FILL;
      endcase
    end
  end

  ldpc_frame_store #(
    .BLK_W(BLK_W), .NUM_BLK(NUM_BLK), .CRC_W(CRC_W),
    .SYS_W(SYS_W), .UNC_W(UNC_W), .PAR_W(PAR_W)
  ) store_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .blk_we_i  (accept),
    .blk_idx_i (blk_cnt_q),
    .blk_data_i(blk_data_i),
    .tail_we_i (last_blk),
    .crc_i     (crc_nxt),
    .aux_i     (aux_i),
    .par_we_i  (par_take),
    .par_i     (parity_i),
    .sys_o     (sys_bits_o),
    .unc_o     (unc_bits),
    .par_o     (par_bits)
  );

  ldpc_frame_label #(
    .NUM_LBL(NUM_LBL), .UNC_PL(UNC_PL), .COD_PL(COD_PL), .SYS_W(SYS_W)
  ) label_i (
    .idx_i  (lbl_cnt_q),
    .unc_i  (unc_bits),
    .sys_i  (sys_bits_o),
    .par_i  (par_bits),
    .label_o(label_o)
  );

  assign blk_ready_o   = (state_q == ST_FILL);
  assign enc_req_o     = (state_q == ST_ENC);
  assign label_valid_o = (state_q == ST_EMIT);
  assign label_sof_o   = label_valid_o && (lbl_cnt_q == '0);
endmodule

// File: rtl/ldpc_frame_asm_chk.sv
module ldpc_frame_asm_chk #(
  parameter int NUM_LBL = 512,
  localparam int CNT_W  = $clog2(NUM_LBL) + 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic blk_ready_o,
  input logic enc_req_o,
  input logic parity_valid_i,
  input logic label_valid_o,
  input logic label_sof_o
);
  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            run_q <= '0;
    else if (label_sof_o)   run_q <= CNT_W'(1);
    else if (label_valid_o) run_q <= run_q + 1'b1;
  end

  // R9
  busy_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({blk_ready_o, enc_req_o, label_valid_o}));

  // R6
  enc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_req_o && !parity_valid_i |=> enc_req_o && !label_valid_o);

  // R7
  first_label_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_req_o && parity_valid_i |=> label_valid_o && label_sof_o);

  // R7
  sof_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    label_sof_o |=> label_valid_o && !label_sof_o);

  // R7
  label_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(label_valid_o) |-> run_q == CNT_W'(NUM_LBL));

  // R9
  ready_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(label_valid_o) |-> blk_ready_o);
endmodule

bind ldpc_frame_asm ldpc_frame_asm_chk #(.NUM_LBL(NUM_LBL)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .blk_ready_o   (blk_ready_o),
  .enc_req_o     (enc_req_o),
  .parity_valid_i(parity_valid_i),
  .label_valid_o (label_valid_o),
  .label_sof_o   (label_sof_o)
);

// File: tb/ldpc_frame_asm_tb_top.sv
module ldpc_frame_asm_tb_top;
  localparam int NB = 50, BW = 65, PW = 3259, SW = 1723, RW = 325, NL = 512;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          blk_valid_i = 1'b0;
  logic [BW-1:0] blk_data_i = '0;
  logic          blk_ready_o;
  logic          aux_i = 1'b0;
  logic          enc_req_o;
  logic [SW-1:0] sys_bits_o;
  logic          parity_valid_i = 1'b0;
  logic [RW-1:0] parity_i = '0;
  logic          label_valid_o, label_sof_o;
  logic [6:0]    label_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  ldpc_frame_asm dut_i (.*);

  function automatic logic [7:0] crc_blk(input logic [7:0] c, input logic [BW-1:0] d);
    logic fb;
    for (int i = 0; i < BW; i++) begin
      fb = c[7] ^ d[i];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  function automatic logic [BW-1:0] rnd_blk();
    return {$urandom, $urandom, $urandom};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // mode: 0 random with gaps, 1 zeros, 2 ones, 3 random no gaps
  task automatic run_frame(input int mode, input logic aux, input int pdly);
    logic [BW-1:0] blks [NB];
    logic [PW-1:0] ep;
    logic [7:0]    c;
    logic [RW-1:0] par;
    logic [2047:0] cw;
    logic [1535:0] got_unc;
    logic [6:0]    exp_l;
    int k;
    bit acc, gap;
    c = 8'h00;
    for (int i = 0; i < NB; i++) begin
      blks[i] = (mode == 1) ? '0 : (mode == 2) ? '1 : rnd_blk();
      c = crc_blk(c, blks[i]);
      ep[i*BW +: BW] = blks[i];
    end
    ep[3250 +: 8] = c;
    ep[PW-1]      = aux;
    par = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
           $urandom, $urandom, $urandom, $urandom, $urandom};
    cw  = {par, ep[SW-1:0]};
    k = 0;
    while (k < NB) begin
      @(negedge clk_i);
      gap = (mode == 0) && ($urandom % 3 == 0);
      blk_valid_i = !gap;
      blk_data_i  = gap ? rnd_blk() : blks[k];
      aux_i       = (k == NB - 1) ? aux : ~aux;  // R5: only last sample counts
      chk(blk_ready_o == 1'b1, "R2", "ready while gathering", 64'(blk_ready_o), 64'd1);
      acc = blk_valid_i && blk_ready_o;
      @(posedge clk_i);
      if (acc) k++;
    end
    @(negedge clk_i);
    blk_valid_i = 1'b1;
    blk_data_i  = rnd_blk();
    aux_i       = ~aux;
    chk(blk_ready_o == 1'b0, "R2", "ready after 50th", 64'(blk_ready_o), 64'd0);
    chk(enc_req_o == 1'b1, "R6", "enc_req rise", 64'(enc_req_o), 64'd1);
    checks++;
    if (sys_bits_o !== ep[SW-1:0]) begin
      errors++;
      $display("FAIL R3 systematic bits: actual %0h expected %0h",
               sys_bits_o[63:0], ep[63:0]);
    end
    for (int d = 0; d < pdly; d++) begin
      @(negedge clk_i);
      blk_data_i = rnd_blk();
      chk(enc_req_o && !label_valid_o, "R6", "waiting for parity",
          64'({enc_req_o, label_valid_o}), 64'h2);
    end
    parity_valid_i = 1'b1;
    parity_i       = par;
    @(posedge clk_i);
    @(negedge clk_i);
    parity_valid_i = 1'b0;
    parity_i       = '0;
    for (int n = 0; n < NL; n++) begin
      if (n > 0) @(negedge clk_i);
      blk_data_i = rnd_blk();
      exp_l = {cw[4*n +: 4], ep[SW + 3*n +: 3]};
      got_unc[3*n +: 3] = label_o[2:0];
      chk(label_valid_o && (label_sof_o == (n == 0)) && !blk_ready_o, "R7", "label strobe",
          64'({label_valid_o, label_sof_o, blk_ready_o}), 64'({1'b1, n == 0, 1'b0}));
      chk(label_o == exp_l, "R8", $sformatf("label %0d", n), 64'(label_o), 64'(exp_l));
    end
    chk(got_unc[3250-SW +: 8] == c, "R4", "crc in labels",
        64'(got_unc[3250-SW +: 8]), 64'(c));
    chk(got_unc[1535] == aux, "R5", "aux position", 64'(got_unc[1535]), 64'(aux));
    @(negedge clk_i);
    blk_valid_i = 1'b0;
    chk(blk_ready_o && !label_valid_o, "R9", "ready after last label",
        64'({blk_ready_o, label_valid_o}), 64'h2);
  endtask

  initial begin
    void'($urandom(32'h1dc0de5));
    repeat (3) @(negedge clk_i);
    chk(blk_ready_o === 1'b1 && enc_req_o === 1'b0 && label_valid_o === 1'b0 &&
        label_sof_o === 1'b0, "R1", "reset outputs",
        64'({blk_ready_o, enc_req_o, label_valid_o, label_sof_o}), 64'h8);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(blk_ready_o == 1'b1 && !enc_req_o, "R1", "after release",
        64'({blk_ready_o, enc_req_o}), 64'h2);
    run_frame(0, 1'b1, 3);   // R3 gaps must not shift positions
    run_frame(1, 1'b1, 0);   // R4 zero data gives zero crc
    run_frame(2, 1'b0, 5);   // R4 taps and bit order
    run_frame(3, 1'b0, 1);   // R10 back to back, crc restart
    run_frame(0, 1'b1, 2);   // R10
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule